// File: doc/BRIEF.md
# Serial Keyboard Command Responder

This block is the keyboard end of a serial keyboard link. The host sends it command bytes. It answers an identify request and a layout query with fixed byte sequences, and it swallows the parameter byte that follows an indicator-light command. Raw key events come in from the key matrix side. Each event carries a 7-bit key number and a release flag in bit 7. The block filters lock-key chatter, handles a one-byte extended-key prefix, translates the key number and appends the result to a receive queue. The host link drains that queue one byte at a time through a pop strobe.

The queue holds 256 bytes by default. A reply replaces the whole queue contents in a single cycle. A key event that arrives in the same cycle as a reply lands directly behind it. The translation step is a compact stand-in for a full scancode table. Plain key numbers pass through unchanged. Extended key numbers are offset by 0x20, modulo 128.

Top module: `kbd_cmd_responder`

## Requirements
- R1: After reset the queue is empty, data_avail_o is 0 and pop_data_o reads 0x00.
- R2: Host command 0x01 empties the queue and leaves exactly the bytes 0xFF, 0x04, 0x7F, in that pop order.
- R3: Host commands 0x07 and 0x0F each empty the queue and leave exactly 0xFE, 0x00.
- R4: Host command 0x0E arms a skip state. The next host byte, whatever its value, is discarded and disarms the skip state.
- R5: Any other host byte leaves the queue contents and order unchanged.
- R6: A key event with code c pushes one byte, {c[7], c[6:0]}: the release flag in bit 7 and the plain translation (identity) in bits 6:0.
- R7: Key event 0xE0 pushes nothing and marks the next emitted event as extended. That event's bits 6:0 become (c[6:0] + 0x20) mod 128. The mark then clears.
- R8: Each of the two lock keys (caps: press 0x3A, release 0xBA; num: press 0x45, release 0xC5) keeps a 2-bit state. A press flips bit 0 and is dropped if the state becomes 2. A release flips bit 1 and is dropped if the state becomes 3. A dropped event does not clear the extended mark.
- R9: The queue pops in first-in first-out order. Once it holds DEPTH bytes, further pushes are dropped.
- R10: While the queue is empty, pop_data_o reads 0x00 and a pop changes nothing. data_avail_o is 1 exactly while at least one byte remains, including after a pop that leaves bytes behind.
- R11: Within one cycle the order is as follows. A reply command discards any pop, then its reply bytes are written, then the key byte. Without a reply, the pop is applied before the key push, so a full queue popped in that cycle accepts the key byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Host command byte strobe |
| cmd_byte_i | input | 8 | Host command byte |
| key_valid_i | input | 1 | Raw key event strobe |
| key_code_i | input | 8 | Raw key event; bit 7 is the release flag |
| pop_i | input | 1 | Remove the head byte of the queue |
| pop_data_o | output | 8 | Head byte of the queue, 0x00 when empty |
| data_avail_o | output | 1 | Queue holds at least one byte |

## Verification
The block has three pieces of hidden state: the skip flag, the extended mark and the two lock states. A wrong skip flag shows up one command later, as either a missing reply or a spurious one. A wrong extended mark or lock state shows up on the next key event, as a byte that is wrong, missing or extra in the queue. Queue pointer or count faults show up on the pop stream, as reordered bytes, a wrong fill limit or a nonzero read when empty. The tests provoke each of these and compare the queue contents pop by pop.

// File: rtl/kbd_resp_pkg.sv
package kbd_resp_pkg;
  localparam int REPLY_MAX = 3;
  localparam int SLOTS = REPLY_MAX + 1;

  localparam logic [7:0] CMD_IDENT   = 8'h01;
  localparam logic [7:0] CMD_LIGHTS  = 8'h0E;
  localparam logic [7:0] CMD_LAYOUT0 = 8'h07;
  localparam logic [7:0] CMD_LAYOUT1 = 8'h0F;
  localparam logic [7:0] KEY_PREFIX  = 8'hE0;

  localparam int NLOCK = 2;
  localparam logic [NLOCK-1:0][7:0] LOCK_DN = {8'h45, 8'h3A};
  localparam logic [NLOCK-1:0][7:0] LOCK_UP = {8'hC5, 8'hBA};

  localparam logic [6:0] EXT_OFFSET = 7'h20;

  function automatic logic [6:0] map_plain(input logic [6:0] c);
    return c;
  endfunction

  function automatic logic [6:0] map_ext(input logic [6:0] c);
    return c + EXT_OFFSET;
  endfunction
endpackage

// File: rtl/kbd_lock_filter.sv
module kbd_lock_filter
  import kbd_resp_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ev_valid_i,
  input  logic [7:0] ev_code_i,
  output logic       emit_o,
  output logic [7:0] emit_byte_o
);
  logic [NLOCK-1:0][1:0] lock_q, lock_d;
  logic ext_q, ext_d;
  logic drop, prefix;

  always_comb begin
    lock_d      = lock_q;
    ext_d       = ext_q;
    drop        = 1'b0;
    prefix      = 1'b0;
    emit_o      = 1'b0;
    emit_byte_o = 8'h00;
    if (ev_valid_i) begin
      for (int i = 0; i < NLOCK; i++) begin
        if (ev_code_i == LOCK_DN[i]) begin
          lock_d[i] = lock_q[i] ^ 2'b01;
          drop = (lock_d[i] == 2'b10);
        end else if (ev_code_i == LOCK_UP[i]) begin
          lock_d[i] = lock_q[i] ^ 2'b10;
          drop = (lock_d[i] == 2'b11);
        end
      end
      if (ev_code_i == KEY_PREFIX) begin
        prefix = 1'b1;
        ext_d  = 1'b1;
      end
      if (!drop && !prefix) begin
        emit_o      = 1'b1;
        ext_d       = 1'b0;
        emit_byte_o = {ev_code_i[7],
                       ext_q ? map_ext(ev_code_i[6:0]) : map_plain(ev_code_i[6:0])};
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lock_q <= '0;
      ext_q  <= 1'b0;
    end else begin
      lock_q <= lock_d;
      ext_q  <= ext_d;
    end
  end
endmodule

// File: rtl/kbd_cmd_decode.sv
module kbd_cmd_decode
  import kbd_resp_pkg::*;
(
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           cmd_valid_i,
  input  logic [7:0]                     cmd_byte_i,
  output logic                           clear_o,
  output logic [REPLY_MAX-1:0]           rep_vld_o,
  output logic [REPLY_MAX-1:0][7:0]      rep_byte_o,
  output logic                           skip_o
);
  logic skip_q, skip_d;

  always_comb begin
    skip_d     = skip_q;
    clear_o    = 1'b0;
    rep_vld_o  = '0;
    rep_byte_o = '0;
    if (cmd_valid_i) begin
      if (skip_q) begin
        skip_d = 1'b0;
      end else begin
        unique case (cmd_byte_i)
          CMD_IDENT: begin
            clear_o    = 1'b1;
            rep_vld_o  = 3'b111;
            rep_byte_o = {8'h7F, 8'h04, 8'hFF};
          end
          CMD_LAYOUT0, CMD_LAYOUT1: begin
            clear_o    = 1'b1;
            rep_vld_o  = 3'b011;
            rep_byte_o = {8'h00, 8'h00, 8'hFE};
          end
          CMD_LIGHTS: skip_d = 1'b1;
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) skip_q <= 1'b0;
    else         skip_q <= skip_d;
  end

  assign skip_o = skip_q;
endmodule

// File: rtl/kbd_byte_queue.sv
module kbd_byte_queue #(
  parameter int DEPTH = 256,
  parameter int NPUSH = 4,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  clear_i,
  input  logic [NPUSH-1:0]      push_vld_i,
  input  logic [NPUSH-1:0][7:0] push_byte_i,
  input  logic                  pop_i,
  output logic [7:0]            head_o,
  output logic                  avail_o,
  output logic [CW-1:0]         count_o
);
  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] rp_q, wp_q, rp_d, wp_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [NPUSH-1:0]         acc;
  logic [NPUSH-1:0][AW-1:0] addr;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    if (clear_i) begin
      rp_d = '0; wp_d = '0; cnt_d = '0;
    end else begin
      rp_d = rp_q; wp_d = wp_q; cnt_d = cnt_q;
      if (pop_i && cnt_q != '0) begin
        rp_d  = bump(rp_q);
        cnt_d = cnt_q - 1'b1;
      end
    end
    for (int k = 0; k < NPUSH; k++) begin
      addr[k] = wp_d;
      acc[k]  = push_vld_i[k] && (cnt_d < CW'(DEPTH));
      if (acc[k]) begin
        wp_d  = bump(wp_d);
        cnt_d = cnt_d + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rp_q <= '0; wp_q <= '0; cnt_q <= '0;
    end else begin
      rp_q <= rp_d; wp_q <= wp_d; cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk_i) begin
    for (int k = 0; k < NPUSH; k++)
      if (acc[k]) mem[addr[k]] <= push_byte_i[k];
  end

  assign avail_o = (cnt_q != '0);
  assign head_o  = avail_o ? mem[rp_q] : 8'h00;
  assign count_o = cnt_q;
endmodule

// File: rtl/kbd_cmd_responder.sv
module kbd_cmd_responder
  import kbd_resp_pkg::*;
#(
  parameter int DEPTH = 256,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cmd_valid_i,
  input  logic [7:0] cmd_byte_i,
  input  logic       key_valid_i,
  input  logic [7:0] key_code_i,
  input  logic       pop_i,
  output logic [7:0] pop_data_o,
  output logic       data_avail_o
);
  logic                      q_clear, skip_mode, key_emit;
  logic [7:0]                key_byte;
  logic [REPLY_MAX-1:0]      rep_vld;
  logic [REPLY_MAX-1:0][7:0] rep_byte;
  logic [SLOTS-1:0]          slot_vld;
  logic [SLOTS-1:0][7:0]     slot_byte;
  logic [CW-1:0]             fill_cnt;

  kbd_cmd_decode u_dec (
    .clk_i, .rst_ni, .cmd_valid_i, .cmd_byte_i,
    .clear_o(q_clear), .rep_vld_o(rep_vld), .rep_byte_o(rep_byte), .skip_o(skip_mode)
  );

  kbd_lock_filter u_flt (
    .clk_i, .rst_ni, .ev_valid_i(key_valid_i), .ev_code_i(key_code_i),
    .emit_o(key_emit), .emit_byte_o(key_byte)
  );

  // reply bytes occupy the low slots, key byte goes last
  assign slot_vld  = {key_emit, rep_vld};
  assign slot_byte = {key_byte, rep_byte};

  kbd_byte_queue #(.DEPTH(DEPTH), .NPUSH(SLOTS)) u_q (
    .clk_i, .rst_ni, .clear_i(q_clear),
    .push_vld_i(slot_vld), .push_byte_i(slot_byte), .pop_i,
    .head_o(pop_data_o), .avail_o(data_avail_o), .count_o(fill_cnt)
  );
endmodule

// File: rtl/kbd_cmd_responder_chk.sv
module kbd_cmd_responder_chk #(
  parameter int DEPTH = 256,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          cmd_valid_i,
  input logic [7:0]    cmd_byte_i,
  input logic          key_valid_i,
  input logic          pop_i,
  input logic [7:0]    pop_data_o,
  input logic          data_avail_o,
  input logic          skip_mode,
  input logic [CW-1:0] fill_cnt
);
  // R9
  fill_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_cnt <= CW'(DEPTH));

  // R10
  empty_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !data_avail_o |-> pop_data_o == 8'h00);

  // R2
  ident_reply_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_i && !skip_mode && cmd_byte_i == 8'h01 && !key_valid_i
    |=> fill_cnt == CW'(3) && pop_data_o == 8'hFF);

  // R3
  layout_reply_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_i && !skip_mode && (cmd_byte_i == 8'h07 || cmd_byte_i == 8'h0F) && !key_valid_i
    |=> fill_cnt == CW'(2) && pop_data_o == 8'hFE);

  // R4
  skip_arm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_i && !skip_mode && cmd_byte_i == 8'h0E |=> skip_mode);

  // R4
  skip_consume_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_i && skip_mode && !key_valid_i && !pop_i |=> !skip_mode && $stable(fill_cnt));

  // R5
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmd_valid_i && !key_valid_i && !pop_i |=> $stable(fill_cnt));
endmodule

bind kbd_cmd_responder kbd_cmd_responder_chk #(.DEPTH(DEPTH)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cmd_valid_i(cmd_valid_i), .cmd_byte_i(cmd_byte_i),
  .key_valid_i(key_valid_i), .pop_i(pop_i), .pop_data_o(pop_data_o),
  .data_avail_o(data_avail_o), .skip_mode(skip_mode), .fill_cnt(fill_cnt)
);

// File: tb/kbd_cmd_responder_test.sv
module kbd_cmd_responder_test;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       cmd_valid_i = 1'b0;
  logic [7:0] cmd_byte_i = 8'h00;
  logic       key_valid_i = 1'b0;
  logic [7:0] key_code_i = 8'h00;
  logic       pop_i = 1'b0;
  logic [7:0] pop_data_o;
  logic       data_avail_o;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  kbd_cmd_responder uut (
    .clk_i(clk), .rst_ni, .cmd_valid_i, .cmd_byte_i, .key_valid_i, .key_code_i,
    .pop_i, .pop_data_o, .data_avail_o
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic send_cmd(input logic [7:0] b);
    cmd_valid_i = 1'b1; cmd_byte_i = b;
    @(negedge clk);
    cmd_valid_i = 1'b0;
  endtask

  task automatic send_key(input logic [7:0] b);
    key_valid_i = 1'b1; key_code_i = b;
    @(negedge clk);
    key_valid_i = 1'b0;
  endtask

  task automatic expect_pop(input string req, input logic [7:0] exp);
    check(req, int'(data_avail_o), 1);
    check(req, int'(pop_data_o), int'(exp));
    pop_i = 1'b1;
    @(negedge clk);
    pop_i = 1'b0;
  endtask

  task automatic expect_empty(input string req);
    check(req, int'(data_avail_o), 0);
    check(req, int'(pop_data_o), 0);
  endtask

  task automatic drain();
    while (data_avail_o) begin
      pop_i = 1'b1;
      @(negedge clk);
      pop_i = 1'b0;
    end
  endtask

  task automatic t_reset();
    expect_empty("R1");
  endtask

  task automatic t_ident();
    send_key(8'h05);
    send_cmd(8'h01);
    expect_pop("R2", 8'hFF);
    expect_pop("R2", 8'h04);
    expect_pop("R2", 8'h7F);
    expect_empty("R2");
  endtask

  task automatic t_layout();
    send_key(8'h06);
    send_cmd(8'h07);
    expect_pop("R3", 8'hFE);
    expect_pop("R3", 8'h00);
    expect_empty("R3");
    send_cmd(8'h0F);
    expect_pop("R3", 8'hFE);
    expect_pop("R3", 8'h00);
    expect_empty("R3");
  endtask

  task automatic t_lights();
    send_cmd(8'h0E);
    send_cmd(8'h01);
    expect_empty("R4");
    send_cmd(8'h07);
    expect_pop("R4", 8'hFE);
    expect_pop("R4", 8'h00);
    expect_empty("R4");
  endtask

  task automatic t_other();
    send_key(8'h10);
    send_cmd(8'h55);
    send_cmd(8'h02);
    expect_pop("R5", 8'h10);
    expect_empty("R5");
  endtask

  task automatic t_key();
    send_key(8'h1E);
    send_key(8'h9E);
    expect_pop("R6", 8'h1E);
    expect_pop("R6", 8'h9E);
    expect_empty("R6");
  endtask

  task automatic t_ext();
    send_key(8'hE0);
    expect_empty("R7");
    send_key(8'h1C);
    send_key(8'h1C);
    send_key(8'hE0);
    send_key(8'hF0);
    expect_pop("R7", 8'h3C);
    expect_pop("R7", 8'h1C);
    expect_pop("R7", 8'h90);
    expect_empty("R7");
  endtask

  task automatic t_lock();
    send_key(8'h3A);
    send_key(8'hBA);
    send_key(8'h3A);
    send_key(8'hBA);
    expect_pop("R8", 8'h3A);
    expect_pop("R8", 8'hBA);
    expect_empty("R8");
    send_key(8'h45);
    send_key(8'hC5);
    send_key(8'hE0);
    send_key(8'h45);
    send_key(8'h11);
    send_key(8'hC5);
    expect_pop("R8", 8'h45);
    expect_pop("R8", 8'h31);
    expect_pop("R8", 8'hC5);
    expect_empty("R8");
  endtask

  task automatic t_full();
    for (int i = 0; i < 260; i++) send_key(8'(i % 100));
    for (int i = 0; i < 256; i++) expect_pop("R9", 8'(i % 100));
    expect_empty("R9");
  endtask

  task automatic t_pop_empty();
    pop_i = 1'b1;
    @(negedge clk);
    pop_i = 1'b0;
    expect_empty("R10");
    send_key(8'h22);
    send_key(8'h23);
    expect_pop("R10", 8'h22);
    check("R10", int'(data_avail_o), 1);
    expect_pop("R10", 8'h23);
    expect_empty("R10");
  endtask

  task automatic t_same_cycle();
    cmd_valid_i = 1'b1; cmd_byte_i = 8'h01; key_valid_i = 1'b1; key_code_i = 8'h11;
    @(negedge clk);
    cmd_valid_i = 1'b0; key_valid_i = 1'b0;
    expect_pop("R11", 8'hFF);
    expect_pop("R11", 8'h04);
    expect_pop("R11", 8'h7F);
    expect_pop("R11", 8'h11);
    expect_empty("R11");
    for (int i = 0; i < 256; i++) send_key(8'h30);
    pop_i = 1'b1; key_valid_i = 1'b1; key_code_i = 8'h31;
    @(negedge clk);
    pop_i = 1'b0; key_valid_i = 1'b0;
    for (int i = 0; i < 255; i++) begin
      pop_i = 1'b1;
      @(negedge clk);
      pop_i = 1'b0;
    end
    expect_pop("R11", 8'h31);
    expect_empty("R11");
    send_key(8'h40);
    send_key(8'h41);
    cmd_valid_i = 1'b1; cmd_byte_i = 8'h07; pop_i = 1'b1;
    @(negedge clk);
    cmd_valid_i = 1'b0; pop_i = 1'b0;
    expect_pop("R11", 8'hFE);
    expect_pop("R11", 8'h00);
    expect_empty("R11");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_ident();
    t_layout();
    t_lights();
    t_other();
    t_key();
    t_ext();
    t_lock();
    t_full();
    t_pop_empty();
    t_same_cycle();
    drain();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule